// File: doc/BRIEF.md
# DAC Register Front End

This block sits between the special-function-register bus of an 8-bit microcontroller and a 12-bit voltage-output converter core. Software writes one control register and two data-byte registers. The block keeps those registers and produces four outputs: the 12-bit code for the converter, an output-pin choice, a range choice and a power-down level. Software can read all three registers back over the same bus.

The code sent to the converter is held in its own register. It changes only when software writes the low data byte. Software therefore loads the high byte first and the low byte second, and the converter never sees a half-updated value. An 8-bit mode takes the code from the low byte alone, with that byte placed at the top of the code. A clear bit, active low, holds both data bytes and the converter code at zero.

Top module: `dac_sfr_frontend`

## Requirements
- R1: After a synchronous active-high reset, all three registers read 0x00, `dacCode` is 0, `pinAlt` and `rangeHigh` are 0, and `powerDown` is 1.
- R2: Writes go to the control register at address 0xFD, the high data byte at 0xFC and the low data byte at 0xFB. Control bits 7:5 are not stored and always read as 0. A write to any other address changes no register and no output.
- R3: In 12-bit mode (control bit 3 = 0), a low-byte write loads `dacCode` with {high byte bits 3:0, written low byte} on that clock edge. The upper nibble of the high byte is stored and reads back, but it never reaches the code.
- R4: `dacCode` changes only on the edge of a low-byte write, or when the clear condition of R6 is active. A write to the high byte or to the control register alone leaves the code unchanged, and this includes a change of the mode bit.
- R5: In 8-bit mode (control bit 3 = 1), a low-byte write loads `dacCode` with {written low byte, 4'b0000}. The high byte has no effect on the code.
- R6: The clear condition is active on every clock edge where the stored control bit 1 is 0, and also on the edge of a control write whose bit 1 is 0. On such an edge both data registers and `dacCode` become 0, and any data-byte write on that edge is discarded.
- R7: `powerDown` equals the inverse of control bit 0. It takes the new value on the clock edge of the control write.
- R8: `pinAlt` equals control bit 4 (1 selects the alternate pin) and `rangeHigh` equals control bit 2. Both take the new value on the clock edge of the control write.
- R9: `sfrRdData` is combinational. While `sfrRd` is 1 and `sfrAddr` matches one of the three registers, it shows that register's stored contents. At every other time it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sfrAddr | input | 8 | Register address on the SFR bus |
| sfrWr | input | 1 | Write strobe, one cycle per write |
| sfrWrData | input | 8 | Write data |
| sfrRd | input | 1 | Read strobe |
| sfrRdData | output | 8 | Read data, 0 when no register is selected |
| dacCode | output | 12 | Code sent to the converter core |
| pinAlt | output | 1 | 1 = drive the alternate pin, 0 = the dedicated pin |
| rangeHigh | output | 1 | 1 = supply range, 0 = reference range |
| powerDown | output | 1 | 1 = converter powered down |

## Verification
Most internal faults show at the ports one clock after the stimulus that exposes them.

- **Corrupted high byte.** It can stay hidden until the next low-byte write. It then appears in `dacCode` bits 11:8 on that edge. A read of address 0xFC shows it at once.
- **Corrupted control bit.** It changes `pinAlt`, `rangeHigh` or `powerDown` on the next edge. The mode and clear bits are the exception: a wrong mode bit shows only at the following low-byte write, and a wrong clear bit shows as data that will not hold.
- **Code register loaded at the wrong time.** This shows as a `dacCode` change on a clock with no low-byte write. The per-clock comparison against the reference model catches it on that same cycle.

// File: rtl/dac_sfr_pkg.sv
package dac_sfr_pkg;

  // Control register bit positions; software depends on these.
  localparam int CTRL_BITS = 5;
  localparam int PIN_BIT   = 4;
  localparam int MODE8_BIT = 3;
  localparam int RANGE_BIT = 2;
  localparam int CLRN_BIT  = 1;
  localparam int EN_BIT    = 0;

  // Decoded strobes sent from the control module to the datapath.
  typedef struct packed {
    logic ctrlWr;
    logic hiWr;
    logic loWr;
    logic ctrlSel;
    logic hiSel;
    logic loSel;
    logic clearNow;
  } sfrStrobe_t;

endpackage

// File: rtl/dac_sfr_ctrl.sv
module dac_sfr_ctrl
  import dac_sfr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'hFD,
  parameter logic [7:0]  HI_ADDR   = 8'hFC,
  parameter logic [7:0]  LO_ADDR   = 8'hFB
) (
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWr,
  input  logic              sfrRd,
  input  logic              wrClrnBit,
  input  logic              clrnQ,
  output sfrStrobe_t        strobe
);

  logic hitCtrl;
  logic hitHi;
  logic hitLo;

  always_comb begin
    hitCtrl = (sfrAddr == CTRL_ADDR[ADDR_W-1:0]);
    hitHi   = (sfrAddr == HI_ADDR[ADDR_W-1:0]);
    hitLo   = (sfrAddr == LO_ADDR[ADDR_W-1:0]);
  end

  always_comb begin
    strobe.ctrlWr  = sfrWr & hitCtrl;
    strobe.hiWr    = sfrWr & hitHi;
    strobe.loWr    = sfrWr & hitLo;
    strobe.ctrlSel = sfrRd & hitCtrl;
    strobe.hiSel   = sfrRd & hitHi;
    strobe.loSel   = sfrRd & hitLo;
    // Clear applies on the edge that writes clear low, and on every edge while it stays low.
    strobe.clearNow = (sfrWr & hitCtrl) ? ~wrClrnBit : ~clrnQ;
  end

endmodule

// File: rtl/dac_sfr_datapath.sv
module dac_sfr_datapath
  import dac_sfr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sfrStrobe_t           strobe,
  input  logic [DATA_W-1:0]    sfrWrData,
  output logic [DATA_W-1:0]    sfrRdData,
  output logic [CTRL_BITS-1:0] ctrlQ,
  output logic [CODE_W-1:0]    dacCode
);

  localparam int HI_W  = CODE_W - DATA_W;
  localparam int PAD_W = CODE_W - DATA_W;
  localparam int RSV_W = DATA_W - CTRL_BITS;

  logic [DATA_W-1:0] hiQ;
  logic [DATA_W-1:0] loQ;
  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] codeNext;

  generate
    if (PAD_W > 0) begin : g_wide
      always_comb begin
        if (ctrlQ[MODE8_BIT])
          codeNext = {sfrWrData, {PAD_W{1'b0}}};
        else
          codeNext = {hiQ[HI_W-1:0], sfrWrData};
      end
    end else begin : g_narrow
      always_comb codeNext = sfrWrData[CODE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
    end else if (strobe.ctrlWr) begin
      ctrlQ <= sfrWrData[CTRL_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearNow) begin
      hiQ   <= '0;
      loQ   <= '0;
      codeQ <= '0;
    end else begin
      if (strobe.hiWr) hiQ <= sfrWrData;
      if (strobe.loWr) begin
        loQ   <= sfrWrData;
        codeQ <= codeNext;
      end
    end
  end

  always_comb begin
    sfrRdData = '0;
    if (strobe.ctrlSel)    sfrRdData = {{RSV_W{1'b0}}, ctrlQ};
    else if (strobe.hiSel) sfrRdData = hiQ;
    else if (strobe.loSel) sfrRdData = loQ;
  end

  assign dacCode = codeQ;

endmodule

// File: rtl/dac_sfr_frontend.sv
module dac_sfr_frontend
  import dac_sfr_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         CODE_W    = 12,
  parameter logic [7:0] CTRL_ADDR = 8'hFD,
  parameter logic [7:0] HI_ADDR   = 8'hFC,
  parameter logic [7:0] LO_ADDR   = 8'hFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWr,
  input  logic [DATA_W-1:0] sfrWrData,
  input  logic              sfrRd,
  output logic [DATA_W-1:0] sfrRdData,
  output logic [CODE_W-1:0] dacCode,
  output logic              pinAlt,
  output logic              rangeHigh,
  output logic              powerDown
);

  sfrStrobe_t           strobe;
  logic [CTRL_BITS-1:0] ctrlQ;

  dac_sfr_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) i_ctrl (
    .sfrAddr  (sfrAddr),
    .sfrWr    (sfrWr),
    .sfrRd    (sfrRd),
    .wrClrnBit(sfrWrData[CLRN_BIT]),
    .clrnQ    (ctrlQ[CLRN_BIT]),
    .strobe   (strobe)
  );

  dac_sfr_datapath #(
    .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .sfrWrData(sfrWrData),
    .sfrRdData(sfrRdData),
    .ctrlQ    (ctrlQ),
    .dacCode  (dacCode)
  );

  assign pinAlt    = ctrlQ[PIN_BIT];
  assign rangeHigh = ctrlQ[RANGE_BIT];
  assign powerDown = ~ctrlQ[EN_BIT];

endmodule

// File: rtl/dac_sfr_checker.sv
module dac_sfr_checker
  import dac_sfr_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         CODE_W    = 12,
  parameter logic [7:0] CTRL_ADDR = 8'hFD,
  parameter logic [7:0] LO_ADDR   = 8'hFB
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic              sfrWr,
  input logic [DATA_W-1:0] sfrWrData,
  input logic              sfrRd,
  input logic [DATA_W-1:0] sfrRdData,
  input logic [CODE_W-1:0] dacCode,
  input logic              pinAlt,
  input logic              powerDown,
  input logic              mode8Q,
  input logic              clrnQ
);

  localparam int PAD_W = CODE_W - DATA_W;

  logic loWrite;
  logic ctrlWrite;
  assign loWrite   = sfrWr && (sfrAddr == LO_ADDR[ADDR_W-1:0]);
  assign ctrlWrite = sfrWr && (sfrAddr == CTRL_ADDR[ADDR_W-1:0]);

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!loWrite && !ctrlWrite) |=> $stable(dacCode)); // R4

  AST_MODE8_CODE: assert property (@(posedge clk) disable iff (rst)
    (loWrite && mode8Q && clrnQ) |=> (dacCode[PAD_W-1:0] == '0) && (dacCode[CODE_W-1 -: DATA_W] == $past(sfrWrData))); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clrnQ |=> (dacCode == '0)); // R6

  AST_POWER_DOWN: assert property (@(posedge clk) disable iff (rst)
    ctrlWrite |=> (powerDown == !$past(sfrWrData[EN_BIT]))); // R7

  AST_PIN_SELECT: assert property (@(posedge clk) disable iff (rst)
    ctrlWrite |=> (pinAlt == $past(sfrWrData[PIN_BIT]))); // R8

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sfrRd && sfrAddr == CTRL_ADDR[ADDR_W-1:0]) |-> (sfrRdData[DATA_W-1:CTRL_BITS] == '0)); // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sfrRd |-> (sfrRdData == '0)); // R9

endmodule

bind dac_sfr_frontend dac_sfr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR)
) i_checker (
  .clk      (clk),
  .rst      (rst),
  .sfrAddr  (sfrAddr),
  .sfrWr    (sfrWr),
  .sfrWrData(sfrWrData),
  .sfrRd    (sfrRd),
  .sfrRdData(sfrRdData),
  .dacCode  (dacCode),
  .pinAlt   (pinAlt),
  .powerDown(powerDown),
  .mode8Q   (ctrlQ[dac_sfr_pkg::MODE8_BIT]),
  .clrnQ    (ctrlQ[dac_sfr_pkg::CLRN_BIT])
);

// File: tb/test_dac_sfr_frontend.sv
`timescale 1ns/1ps
module test_dac_sfr_frontend;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sfrAddr = 8'h00;
  logic        sfrWr = 1'b0;
  logic [7:0]  sfrWrData = 8'h00;
  logic        sfrRd = 1'b0;
  logic [7:0]  sfrRdData;
  logic [11:0] dacCode;
  logic        pinAlt, rangeHigh, powerDown;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int mCtrl = 0, mHi = 0, mLo = 0, mCode = 0;

  always #2 clk = ~clk;

  dac_sfr_frontend i_dac_sfr_frontend (
    .clk(clk), .rst(rst), .sfrAddr(sfrAddr), .sfrWr(sfrWr), .sfrWrData(sfrWrData),
    .sfrRd(sfrRd), .sfrRdData(sfrRdData), .dacCode(dacCode), .pinAlt(pinAlt),
    .rangeHigh(rangeHigh), .powerDown(powerDown)
  );

  // Reference model, written from the requirements
  always @(posedge clk) begin
    int newCtrl;
    bit clearing;
    if (rst) begin
      mCtrl = 0; mHi = 0; mLo = 0; mCode = 0;
    end else begin
      newCtrl = mCtrl;
      if (sfrWr && sfrAddr == 8'hFD) newCtrl = sfrWrData & 8'h1F;
      clearing = ((newCtrl >> 1) & 1) == 0;
      if (!clearing) begin
        if (sfrWr && sfrAddr == 8'hFC) mHi = sfrWrData;
        if (sfrWr && sfrAddr == 8'hFB) begin
          mLo = sfrWrData;
          if ((mCtrl >> 3) & 1) mCode = sfrWrData * 16;
          else mCode = (mHi % 16) * 256 + sfrWrData;
        end
      end else begin
        mHi = 0; mLo = 0; mCode = 0;
      end
      mCtrl = newCtrl;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compare every output against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 cycle dacCode", dacCode, mCode);
      check("R7 cycle powerDown", powerDown, ((mCtrl & 1) == 0) ? 1 : 0);
      check("R8 cycle pinAlt", pinAlt, (mCtrl >> 4) & 1);
      check("R8 cycle rangeHigh", rangeHigh, (mCtrl >> 2) & 1);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWr = 1'b1;
    @(negedge clk);
    sfrWr = 1'b0;
    #0.5;
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input int exp);
    sfrAddr = a; sfrRd = 1'b1;
    #0.5;
    check(tag, sfrRdData, exp);
    sfrRd = 1'b0;
    #0.5;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.5;
    check("R1 reset dacCode", dacCode, 0);
    check("R1 reset powerDown", powerDown, 1);
    check("R1 reset pinAlt", pinAlt, 0);
    check("R1 reset rangeHigh", rangeHigh, 0);
    rdCheck("R1 reset ctrl read", 8'hFD, 8'h00);
    rdCheck("R1 reset hi read", 8'hFC, 8'h00);
    rdCheck("R1 reset lo read", 8'hFB, 8'h00);

    wr(8'hFC, 8'hAB);
    rdCheck("R6 hi write ignored while clear low", 8'hFC, 8'h00);

    wr(8'hFD, 8'hFF);
    rdCheck("R2 control reserved bits read zero", 8'hFD, 8'h1F);
    check("R8 pinAlt set", pinAlt, 1);
    check("R8 rangeHigh set", rangeHigh, 1);
    check("R7 powered up", powerDown, 0);

    wr(8'hFB, 8'h5C);
    check("R5 8-bit code", dacCode, 12'h5C0);
    wr(8'hFC, 8'h37);
    check("R4 hi write alone holds code", dacCode, 12'h5C0);
    wr(8'hFB, 8'h5C);
    check("R5 hi byte ignored in 8-bit mode", dacCode, 12'h5C0);

    wr(8'hFD, 8'h03);
    check("R4 mode change alone holds code", dacCode, 12'h5C0);
    check("R8 pinAlt cleared", pinAlt, 0);
    wr(8'hFC, 8'hA7);
    rdCheck("R3 upper nibble stored", 8'hFC, 8'hA7);
    check("R4 hi write holds code 12-bit", dacCode, 12'h5C0);
    wr(8'hFB, 8'h21);
    check("R3 12-bit right-justified code", dacCode, 12'h721);
    rdCheck("R3 lo read back", 8'hFB, 8'h21);

    sfrAddr = 8'hFC; #0.5;
    check("R9 no read strobe gives zero", sfrRdData, 0);
    rdCheck("R9 unmapped read zero", 8'h80, 8'h00);

    wr(8'h10, 8'hFF);
    rdCheck("R2 unmapped write leaves ctrl", 8'hFD, 8'h03);
    rdCheck("R2 unmapped write leaves hi", 8'hFC, 8'hA7);
    check("R2 unmapped write leaves code", dacCode, 12'h721);

    wr(8'hFD, 8'h01);
    check("R6 clear zeroes code same edge", dacCode, 0);
    rdCheck("R6 clear zeroes hi", 8'hFC, 8'h00);
    rdCheck("R6 clear zeroes lo", 8'hFB, 8'h00);
    wr(8'hFB, 8'h44);
    check("R6 lo write ignored while clear low", dacCode, 0);

    wr(8'hFD, 8'h02);
    check("R7 power down", powerDown, 1);
    wr(8'hFC, 8'h0F);
    wr(8'hFB, 8'hFF);
    check("R3 full-scale 12-bit code", dacCode, 12'hFFF);

    wr(8'hFD, 8'h0A);
    check("R4 mode to 8-bit holds code", dacCode, 12'hFFF);
    wr(8'hFB, 8'hFF);
    check("R5 full-scale 8-bit code", dacCode, 12'hFF0);
    wr(8'hFB, 8'h00);
    check("R5 zero 8-bit code", dacCode, 12'h000);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule